// File: doc/BRIEF.md
# Dispatch Group Slot Allocator

This block takes the oldest few decoded operations waiting for dispatch and packs them, strictly in program order, into a dispatch group of five slots. Each cycle it works out how many of those operations fit under the slot placement rules. It tells the upstream queue that count, so the queue can pop those entries. It then registers the group: a valid bit per slot, which head entry each slot holds, and the execution pipe each slot is sent to.

Each head entry carries a 3-bit class and a 2-bit crack code. The class is one of integer, load/store, floating point, vector, vector permute, branch, condition-register and special-register move. The crack code gives the number of internal ops: 0 means one, 1 means two, and 2 or 3 mean four. Slot position decides the pipe for paired units and limits where an operation may sit. Branches go only in the last slot. Some classes go only in the first slot. Cracked operations need adjacent slots inside fixed windows. The first operation that cannot legally be placed ends the group and stays at the head for the next cycle.

Top module: `dispatch_slot_alloc`

## Requirements
- R1: At most five operations are accepted per cycle, and `take_cnt` never exceeds the number of leading valid head entries. Slot k (k=0..4, "slot k+1") reports in `grp_op[3k+:3]` the head offset of the operation it holds.
- R2: Operations take slots in program order. Slot numbers never decrease from one operation to the next, and no later operation fills a slot before an earlier one's.
- R3: A branch (class 5) is placed only in slot 5, with pipe code 9, whatever slots are still empty before it. Placing it closes the group.
- R4: Single integer (class 0), load/store (class 1) and floating-point (class 2) ops steer by slot. Slots 1 and 4 go to the first pipe of the pair (codes 1, 3, 5). Slots 2 and 3 go to the second pipe (codes 2, 4, 6).
- R5: An op cracked into two takes two adjacent slots, starting no later than slot 3. Each of its slots is steered by its own position.
- R6: An op cracked into four takes slots 1 to 4 and is placed only as the first op of a group.
- R7: Condition-register ops (class 6, pipe code 10) and special-register moves (class 7, pipe code 9) are placed only in slot 1.
- R8: Vector ops (class 3) may use any of slots 1 to 4 and steer to pipe code 7. Vector permutes (class 4) steer to pipe code 8.
- R9: The first op that cannot be placed ends the group. It and every later op are left out of `take_cnt`.
- R10: The group appears on `grp_vld`/`grp_op`/`grp_pipe` one cycle after the head window that formed it. A synchronous reset clears every slot to invalid with op and pipe 0.
- R11: Only the contiguous run of valid head entries starting at entry 0 is considered. A valid entry after an invalid one is ignored.
- R12: The crack code is ignored for branch, condition-register and special-register classes; each takes one slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hd_vld | input | 5 | Valid bit per head entry, entry 0 oldest |
| hd_cls | input | 15 | 3-bit class per head entry |
| hd_crack | input | 10 | 2-bit crack code per head entry |
| take_cnt | output | 3 | Number of head entries accepted this cycle (pop count) |
| grp_vld | output | 5 | Registered valid bit per slot |
| grp_op | output | 15 | Registered 3-bit head offset per slot |
| grp_pipe | output | 20 | Registered 4-bit pipe code per slot (0 none) |

## Verification
Two functions often fall in the same cycle. One is a branch closing the group in slot 5. The other is a cracked or paired op filling the earlier slots: a four-way crack followed by a branch, or a two-way floating-point op, a vector op and then a branch with slot 4 left empty. The bench builds these head windows directly. It judges them by the pop count in the same cycle and by the full slot map of offsets and pipes one cycle later. It also forms full groups where the fifth op is blocked, to confirm that the blocked op is not counted.

// File: rtl/dispatch_slot_alloc.sv
module dispatch_slot_alloc #(
  parameter int NSLOT = 5,
  parameter int CW    = 3,
  parameter int KW    = 2,
  parameter int PW    = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NSLOT-1:0]     hd_vld,
  input  logic [NSLOT*CW-1:0]  hd_cls,
  input  logic [NSLOT*KW-1:0]  hd_crack,
  output logic [2:0]           take_cnt,
  output logic [NSLOT-1:0]     grp_vld,
  output logic [NSLOT*3-1:0]   grp_op,
  output logic [NSLOT*PW-1:0]  grp_pipe
);
  localparam int LAST = NSLOT - 1;

  localparam logic [CW-1:0] C_INT = 3'd0, C_LSU = 3'd1, C_FPU = 3'd2, C_VEC = 3'd3,
                            C_VPM = 3'd4, C_BR  = 3'd5, C_CR  = 3'd6, C_SPR = 3'd7;
  localparam logic [PW-1:0] P_NONE = 4'd0, P_INT1 = 4'd1, P_INT2 = 4'd2, P_LSU1 = 4'd3,
                            P_LSU2 = 4'd4, P_FPU1 = 4'd5, P_FPU2 = 4'd6, P_VEC = 4'd7,
                            P_VPM  = 4'd8, P_BRU  = 4'd9, P_CRU  = 4'd10;

  logic [NSLOT-1:0]    nxt_vld;
  logic [NSLOT*3-1:0]  nxt_op;
  logic [NSLOT*PW-1:0] nxt_pipe;
  logic [2:0]          take;

  function automatic logic [PW-1:0] steer(input logic [CW-1:0] c, input int s);
    logic prim;
    prim = (s == 0) || (s == 3);
    case (c)
      C_INT:   steer = prim ? P_INT1 : P_INT2;
      C_LSU:   steer = prim ? P_LSU1 : P_LSU2;
      C_FPU:   steer = prim ? P_FPU1 : P_FPU2;
      C_VEC:   steer = P_VEC;
      C_VPM:   steer = P_VPM;
      default: steer = P_NONE;
    endcase
  endfunction

  always_comb begin
    int pos;
    int n;
    logic done;
    logic [CW-1:0] c;
    nxt_vld  = '0;
    nxt_op   = '0;
    nxt_pipe = '0;
    take     = '0;
    pos      = 0;
    done     = 1'b0;
    for (int k = 0; k < NSLOT; k++) begin
      c = hd_cls[k*CW +: CW];
      case (hd_crack[k*KW +: KW])
        2'd0:    n = 1;
        2'd1:    n = 2;
        default: n = 4;
      endcase
      if (!hd_vld[k]) done = 1'b1;
      if (!done) begin
        if (c == C_BR) begin
          nxt_vld[LAST]           = 1'b1;
          nxt_op[LAST*3 +: 3]     = 3'(k);
          nxt_pipe[LAST*PW +: PW] = P_BRU;
          take = take + 3'd1;
          done = 1'b1;
        end else if (c == C_CR || c == C_SPR) begin
          if (pos == 0) begin
            nxt_vld[0]      = 1'b1;
            nxt_op[2:0]     = 3'(k);
            nxt_pipe[PW-1:0] = (c == C_CR) ? P_CRU : P_BRU;
            pos  = 1;
            take = take + 3'd1;
          end else done = 1'b1;
        end else if ((n == 1 && pos <= 3) || (n == 2 && pos <= 2) || (n == 4 && pos == 0)) begin
          for (int s = 0; s < LAST; s++) begin
            if (s >= pos && s < pos + n) begin
              nxt_vld[s]           = 1'b1;
              nxt_op[s*3 +: 3]     = 3'(k);
              nxt_pipe[s*PW +: PW] = steer(c, s);
            end
          end
          pos  = pos + n;
          take = take + 3'd1;
        end else done = 1'b1;
      end
    end
  end

  assign take_cnt = take;

  always_ff @(posedge clk) begin
    if (rst) begin
      grp_vld  <= '0;
      grp_op   <= '0;
      grp_pipe <= '0;
    end else begin
      grp_vld  <= nxt_vld;
      grp_op   <= nxt_op;
      grp_pipe <= nxt_pipe;
    end
  end

  // R1
  take_le_avail_chk: assert property (@(posedge clk) disable iff (rst)
    take_cnt <= 3'($countones(hd_vld)));

  // R10
  group_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
    (take_cnt != 3'd0) |=> (grp_vld != '0));

  // R3
  branch_last_slot_chk: assert property (@(posedge clk) disable iff (rst)
    grp_vld[LAST] |-> (grp_pipe[LAST*PW +: PW] == P_BRU));

  always_comb begin
    if (!rst) begin
      for (int s = 0; s < LAST; s++) begin
        // R2
        slot_order_chk: assert (!(grp_vld[s] && grp_vld[s+1]) ||
                                (grp_op[s*3 +: 3] <= grp_op[(s+1)*3 +: 3]));
        // R3
        no_early_branch_chk: assert (!grp_vld[s] || (grp_pipe[s*PW +: PW] != P_BRU) ||
                                     (s == 0 && grp_op[2:0] == 3'd0));
      end
    end
  end
endmodule

// File: tb/dispatch_slot_alloc_tb_top.sv
module dispatch_slot_alloc_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  hd_vld = '0;
  logic [14:0] hd_cls = '0;
  logic [9:0]  hd_crack = '0;
  logic [2:0]  take_cnt;
  logic [4:0]  grp_vld;
  logic [14:0] grp_op;
  logic [19:0] grp_pipe;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    logic [2:0]  take;
    logic [4:0]  vld;
    logic [14:0] op;
    logic [19:0] pipe;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  exp_t prev;
  bit   have_prev = 0;

  always #5 clk = ~clk;

  dispatch_slot_alloc dut_i (
    .clk(clk), .rst(rst), .hd_vld(hd_vld), .hd_cls(hd_cls), .hd_crack(hd_crack),
    .take_cnt(take_cnt), .grp_vld(grp_vld), .grp_op(grp_op), .grp_pipe(grp_pipe)
  );

  task automatic drive(input logic [4:0] v, input logic [14:0] c, input logic [9:0] k,
                       input logic [2:0] et, input logic [4:0] ev, input logic [14:0] eo,
                       input logic [19:0] ep, input string tag);
    exp_t e;
    @(posedge clk);
    #2;
    hd_vld = v; hd_cls = c; hd_crack = k;
    e.take = et; e.vld = ev; e.op = eo; e.pipe = ep; e.tag = tag;
    exp_q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (have_prev) begin
      tests++;
      if (grp_vld !== prev.vld || grp_op !== prev.op || grp_pipe !== prev.pipe) begin
        fails++;
        $display("FAIL %s group: vld=%b op=%h pipe=%h expected vld=%b op=%h pipe=%h",
                 prev.tag, grp_vld, grp_op, grp_pipe, prev.vld, prev.op, prev.pipe);
      end
      have_prev = 0;
    end
    if (exp_q.size() != 0) begin
      prev = exp_q.pop_front();
      tests++;
      if (take_cnt !== prev.take) begin
        fails++;
        $display("FAIL %s take: got %0d expected %0d", prev.tag, take_cnt, prev.take);
      end
      have_prev = 1;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    tests++;
    if (grp_vld !== 5'b0 || grp_pipe !== 20'h0) begin
      fails++;
      $display("FAIL R10 reset: vld=%b pipe=%h expected 0", grp_vld, grp_pipe);
    end
    rst = 1'b0;
    // classes: 0 INT 1 LSU 2 FPU 3 VEC 4 VPM 5 BR 6 CR 7 SPR
    drive(5'b11111, {3'd0,3'd0,3'd0,3'd0,3'd0}, 10'h0, 3'd4, 5'b01111,
          {3'd0,3'd3,3'd2,3'd1,3'd0}, {4'd0,4'd1,4'd2,4'd2,4'd1}, "R4/R9 int fill");
    drive(5'b00111, {3'd0,3'd0,3'd5,3'd0,3'd0}, 10'h0, 3'd3, 5'b10011,
          {3'd2,3'd0,3'd0,3'd1,3'd0}, {4'd9,4'd0,4'd0,4'd2,4'd1}, "R3 branch skip");
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd0,3'd5}, 10'h0, 3'd1, 5'b10000,
          {3'd0,3'd0,3'd0,3'd0,3'd0}, {4'd9,4'd0,4'd0,4'd0,4'd0}, "R3 branch first");
    drive(5'b00111, {3'd0,3'd0,3'd1,3'd0,3'd0}, {2'd0,2'd0,2'd0,2'd1,2'd0}, 3'd3, 5'b01111,
          {3'd0,3'd2,3'd1,3'd1,3'd0}, {4'd0,4'd3,4'd2,4'd2,4'd1}, "R5 pair mid");
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd1,3'd0}, {2'd0,2'd0,2'd0,2'd2,2'd0}, 3'd1, 5'b00001,
          15'h0, {4'd0,4'd0,4'd0,4'd0,4'd1}, "R6 quad late");
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd5,3'd1}, {2'd0,2'd0,2'd0,2'd0,2'd2}, 3'd2, 5'b11111,
          {3'd1,3'd0,3'd0,3'd0,3'd0}, {4'd9,4'd3,4'd4,4'd4,4'd3}, "R6 quad+branch");
    drive(5'b01111, {3'd0,3'd2,3'd0,3'd0,3'd0}, {2'd0,2'd1,2'd0,2'd0,2'd0}, 3'd3, 5'b00111,
          {3'd0,3'd0,3'd2,3'd1,3'd0}, {4'd0,4'd0,4'd2,4'd2,4'd1}, "R5 pair past slot3");
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd6,3'd6}, 10'h0, 3'd1, 5'b00001,
          15'h0, {4'd0,4'd0,4'd0,4'd0,4'd10}, "R7 cr twice");
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd7,3'd0}, 10'h0, 3'd1, 5'b00001,
          15'h0, {4'd0,4'd0,4'd0,4'd0,4'd1}, "R7 spr late");
    drive(5'b01111, {3'd0,3'd4,3'd3,3'd4,3'd3}, 10'h0, 3'd4, 5'b01111,
          {3'd0,3'd3,3'd2,3'd1,3'd0}, {4'd0,4'd8,4'd7,4'd8,4'd7}, "R8 vector");
    drive(5'b00101, {3'd0,3'd0,3'd2,3'd0,3'd2}, 10'h0, 3'd1, 5'b00001,
          15'h0, {4'd0,4'd0,4'd0,4'd0,4'd5}, "R11 gap");
    drive(5'b00000, 15'h0, 10'h0, 3'd0, 5'b00000, 15'h0, 20'h0, "R10 empty");
    drive(5'b00001, {3'd0,3'd0,3'd0,3'd0,3'd5}, {2'd0,2'd0,2'd0,2'd0,2'd2}, 3'd1, 5'b10000,
          15'h0, {4'd9,4'd0,4'd0,4'd0,4'd0}, "R12 branch crack");
    drive(5'b00011, {3'd0,3'd0,3'd0,3'd0,3'd7}, {2'd0,2'd0,2'd0,2'd0,2'd1}, 3'd2, 5'b00011,
          {3'd0,3'd0,3'd0,3'd1,3'd0}, {4'd0,4'd0,4'd0,4'd2,4'd9}, "R12 spr crack");
    drive(5'b00111, {3'd0,3'd0,3'd5,3'd3,3'd2}, {2'd0,2'd0,2'd0,2'd0,2'd1}, 3'd3, 5'b10111,
          {3'd2,3'd0,3'd1,3'd0,3'd0}, {4'd9,4'd0,4'd7,4'd6,4'd5}, "R2 fpu pair vec branch");
    drive(5'b11111, {3'd5,3'd0,3'd0,3'd0,3'd0}, 10'h0, 3'd5, 5'b11111,
          {3'd4,3'd3,3'd2,3'd1,3'd0}, {4'd9,4'd1,4'd2,4'd2,4'd1}, "R1 five ops");
    @(posedge clk);
    #2;
    hd_vld = 5'b00000;
    repeat (2) @(posedge clk);
    // R10 reset discards a group in formation
    #2;
    hd_vld = 5'b11111; hd_cls = {3'd5,3'd0,3'd0,3'd0,3'd0}; hd_crack = '0;
    rst = 1'b1;
    @(posedge clk);
    #2;
    tests++;
    if (grp_vld !== 5'b0 || grp_op !== 15'h0 || grp_pipe !== 20'h0) begin
      fails++;
      $display("FAIL R10 mid reset: vld=%b op=%h pipe=%h expected 0", grp_vld, grp_op, grp_pipe);
    end
    rst = 1'b0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule